// File: doc/BRIEF.md
# Pipelined Tree Magnitude Comparator

This block decides whether one unsigned operand is strictly larger than another. Every bit position is reduced to a two-bit code: a "greater" flag, and a "defer" flag meaning that the two bits match and the decision belongs to less significant bits. A balanced binary tree of two-bit 2:1 selectors then merges neighbouring codes. At each node the more significant half wins unless it defers, in which case the less significant half's code passes upward. The combinational depth is therefore log2(WIDTH) selector levels.

Registers can sit between tree levels. `REG_STRIDE` = 1 puts a register after every level, so the clock period covers one selector. `REG_STRIDE` = 2 puts one after every second level, and always after the root. This roughly halves the register count, and each stage then spans two selector levels. A valid bit travels alongside the codes so that `out_valid` marks the cycle in which `a_gt_b` belongs to a given operand pair.

Top module: `tree_gt_cmp`

## Requirements
- R1: When `out_valid` is 1, `a_gt_b` is 1 exactly when `op_a` is greater than `op_b` as unsigned numbers, for the operand pair accepted with `in_valid`.
- R2: Equal operands, including all-zero and all-one values, give `a_gt_b` = 0.
- R3: The most significant bit position where the operands differ decides the result, whatever the lower bits hold. For example, 8'h80 against 8'h7F gives 1, and 8'h7F against 8'h80 gives 0.
- R4: `out_valid` rises exactly LAT cycles after the edge that samples `in_valid` = 1. LAT = ceil(log2(WIDTH) / REG_STRIDE), which is 3 for the defaults WIDTH = 8 and REG_STRIDE = 1.
- R5: With `in_valid` held at 1, one result leaves the block each clock, in the order the pairs were accepted.
- R6: Operands presented while `in_valid` is 0 are ignored, and `a_gt_b` keeps the last valid result until the next valid result arrives.
- R7: While `rst_n` is low, `out_valid` and `a_gt_b` are 0, and every pipeline register is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | The operand pair is to be compared |
| op_a | input | WIDTH | Unsigned operand A |
| op_b | input | WIDTH | Unsigned operand B |
| out_valid | output | 1 | `a_gt_b` carries a new result |
| a_gt_b | output | 1 | 1 when A > B for that result |

## Verification
The bench targets several ways the tree could go wrong. Pairs that match everywhere would expose a merge that reports "greater" from a deferring code, so equal values would read as 1. Pairs that differ only in the top bit, with the lower bits set the opposite way, would expose a node that takes the wrong half or ignores the defer flag. Bubbles with busy operand lines would expose registers that load without a valid, so a stale or unrequested result would appear on `a_gt_b`. An unbroken stream would show a valid bit that is skewed against the data by even one stage, because every result would then belong to the wrong pair.

// File: rtl/cmp_tree_pkg.sv
package cmp_tree_pkg;

  // Two-bit code produced by a bit slice and by every merge node.
  // gt    : this span alone decides that A > B
  // defer : this span is equal; the decision belongs to lower bits
  // gt=0, defer=0 means A < B within the span.
  typedef struct packed {
    logic gt;
    logic defer;
  } cmp_code_t;

endpackage

// File: rtl/cmp_bit_slice.sv
module cmp_bit_slice
  import cmp_tree_pkg::*;
(
  input  logic      a_bit,
  input  logic      b_bit,
  output cmp_code_t code
);

  always_comb begin
    code.gt    = a_bit & ~b_bit;
    code.defer = ~(a_bit ^ b_bit);
  end

endmodule

// File: rtl/cmp_merge_node.sv
module cmp_merge_node
  import cmp_tree_pkg::*;
(
  input  cmp_code_t hi_code,
  input  cmp_code_t lo_code,
  output cmp_code_t out_code
);

  // The upper half decides unless it is equal; then the lower half passes.
  always_comb begin
    if (hi_code.defer) out_code = lo_code;
    else               out_code = hi_code;
  end

endmodule

// File: rtl/cmp_tree_level.sv
module cmp_tree_level
  import cmp_tree_pkg::*;
#(
  parameter int IN_CNT     = 2,
  parameter bit REGISTERED = 1'b1,
  localparam int OUT_CNT   = IN_CNT / 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  cmp_code_t [IN_CNT-1:0]  in_codes,
  output logic                    out_valid,
  output cmp_code_t [OUT_CNT-1:0] out_codes
);

  cmp_code_t [OUT_CNT-1:0] merged;

  for (genvar j = 0; j < OUT_CNT; j++) begin : g_node
    cmp_merge_node u_node (
      .hi_code  (in_codes[2*j+1]),
      .lo_code  (in_codes[2*j]),
      .out_code (merged[j])
    );
  end

  if (REGISTERED) begin : g_reg
    cmp_code_t [OUT_CNT-1:0] codes_q, codes_d;
    logic                    valid_q, valid_d;
    logic                    armed_q;

    // Next-state: codes load only with a valid (clock enable).
    always_comb begin
      valid_d = in_valid;
      codes_d = codes_q;
      if (in_valid) codes_d = merged;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        codes_q <= '0;
        valid_q <= 1'b0;
        armed_q <= 1'b0;
      end else begin
        codes_q <= codes_d;
        valid_q <= valid_d;
        armed_q <= 1'b1;
      end
    end

    assign out_codes = codes_q;
    assign out_valid = valid_q;

    assert_stage_valid_delay_R4: assert property (
      @(posedge clk) disable iff (!rst_n)
      armed_q |-> (out_valid == $past(in_valid)));

    assert_stage_hold_R6: assert property (
      @(posedge clk) disable iff (!rst_n)
      (armed_q && !$past(in_valid)) |-> $stable(out_codes));

  end else begin : g_comb
    assign out_codes = merged;
    assign out_valid = in_valid;
  end

endmodule

// File: rtl/tree_gt_cmp.sv
module tree_gt_cmp
  import cmp_tree_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int REG_STRIDE = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic             out_valid,
  output logic             a_gt_b
);

  localparam int LEVELS = $clog2(WIDTH);
  localparam int STAGES = (LEVELS + REG_STRIDE - 1) / REG_STRIDE;
  localparam int CW     = $clog2(STAGES + 1);

  if (WIDTH < 2 || (1 << LEVELS) != WIDTH || REG_STRIDE < 1 || REG_STRIDE > 2)
  begin : g_bad_param
    $error("tree_gt_cmp: WIDTH must be a power of two >= 2, REG_STRIDE 1 or 2");
  end

  cmp_code_t [WIDTH-1:0] lvl_codes [0:LEVELS];
  logic                  lvl_valid [0:LEVELS];

  // Leaf slices.
  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    cmp_bit_slice u_slice (
      .a_bit (op_a[i]),
      .b_bit (op_b[i]),
      .code  (lvl_codes[0][i])
    );
  end
  assign lvl_valid[0] = in_valid;

  // Merge levels; a register follows every REG_STRIDE-th level and the root.
  for (genvar k = 1; k <= LEVELS; k++) begin : g_level
    localparam int  IN_CNT = WIDTH >> (k - 1);
    localparam bit  DO_REG = ((k % REG_STRIDE) == 0) || (k == LEVELS);

    cmp_tree_level #(
      .IN_CNT     (IN_CNT),
      .REGISTERED (DO_REG)
    ) u_level (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (lvl_valid[k-1]),
      .in_codes  (lvl_codes[k-1][IN_CNT-1:0]),
      .out_valid (lvl_valid[k]),
      .out_codes (lvl_codes[k][IN_CNT/2-1:0])
    );

    assign lvl_codes[k][WIDTH-1:IN_CNT/2] = '0;
  end

  assign out_valid = lvl_valid[LEVELS];
  assign a_gt_b    = lvl_codes[LEVELS][0].gt;

  // Cycles since reset release, saturating at the pipeline depth.
  logic [CW-1:0] warm_d, warm_q;

  always_comb begin
    warm_d = warm_q;
    if (warm_q != CW'(STAGES)) warm_d = warm_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= '0;
    else        warm_q <= warm_d;
  end

  assert_latency_match_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
    (warm_q == CW'(STAGES)) |-> (out_valid == $past(in_valid, STAGES)));

  assert_equal_gives_zero_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    (out_valid && lvl_codes[LEVELS][0].defer) |-> !a_gt_b);

  assert_result_hold_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(a_gt_b));

  assert_reset_clear_R7: assert property (
    @(posedge clk) disable iff (!rst_n)
    (warm_q == '0) |-> (!out_valid && !a_gt_b));

endmodule

// File: tb/sim_tree_gt_cmp.sv
`timescale 1ns/1ps
module sim_tree_gt_cmp;

  localparam int W      = 8;
  localparam int STRIDE = 1;
  localparam int LV     = $clog2(W);
  localparam int LAT    = (LV + STRIDE - 1) / STRIDE;
  localparam int HSZ    = 8192;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [W-1:0] op_a, op_b;
  logic         out_valid, a_gt_b;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  logic held   = 1'b0;
  bit  finished = 1'b0;

  logic  hv [HSZ];
  logic  he [HSZ];
  string ht [HSZ];

  always #5 clk = ~clk;

  tree_gt_cmp #(.WIDTH(W), .REG_STRIDE(STRIDE)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .a_gt_b(a_gt_b)
  );

  function automatic logic model_gt(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a > b) ? 1'b1 : 1'b0;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // At a falling edge: check outputs due now, then drive the next inputs.
  task automatic step(input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic v, input string tag);
    logic  ev, er;
    string et;
    @(negedge clk);
    ev = 1'b0; er = held; et = "R6";
    if (cyc >= LAT && hv[(cyc-LAT)%HSZ]) begin
      ev = 1'b1; er = he[(cyc-LAT)%HSZ]; et = ht[(cyc-LAT)%HSZ];
      held = er;
    end
    check("R4 out_valid", out_valid, ev);
    check(et, a_gt_b, er);
    in_valid = v; op_a = a; op_b = b;
    hv[cyc%HSZ] = v;
    he[cyc%HSZ] = model_gt(a, b);
    ht[cyc%HSZ] = tag;
    cyc++;
  endtask

  initial begin
    #(2_000_000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b1; op_a = '1; op_b = '0;
    repeat (3) @(negedge clk);
    // R7: reset clears outputs even with a valid pending on the inputs
    check("R7 out_valid", out_valid, 1'b0);
    check("R7 a_gt_b", a_gt_b, 1'b0);
    in_valid = 1'b0; op_a = '0; op_b = '0;
    @(negedge clk);
    rst_n = 1'b1;

    // R2: equal operands
    step(8'h00, 8'h00, 1'b1, "R2 zeros");
    step(8'hFF, 8'hFF, 1'b1, "R2 ones");
    step(8'h5A, 8'h5A, 1'b1, "R2 mixed");
    // R3: top bit decides against opposite lower bits
    step(8'h80, 8'h7F, 1'b1, "R3 msb A");
    step(8'h7F, 8'h80, 1'b1, "R3 msb B");
    step(8'h01, 8'h00, 1'b1, "R1 lsb A");
    step(8'h00, 8'h01, 1'b1, "R1 lsb B");
    step(8'hFF, 8'hFE, 1'b1, "R1 lsb only");
    step(8'h10, 8'h0F, 1'b1, "R3 mid bit");
    // R6: bubbles with busy operands after a result of 1
    step(8'h81, 8'h01, 1'b1, "R1 set one");
    for (int i = 0; i < 6; i++) step(8'h00, 8'hFF, 1'b0, "R6");
    step(8'h02, 8'h40, 1'b1, "R1 set zero");
    for (int i = 0; i < 6; i++) step(8'hFF, 8'h00, 1'b0, "R6");

    // R5: unbroken stream
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] a, b;
      a = W'($urandom);
      b = (i % 7 == 0) ? a : W'($urandom);
      step(a, b, 1'b1, "R5 stream");
    end

    // R1/R6: random with bubbles, including near-equal pairs
    for (int i = 0; i < 1500; i++) begin
      logic [W-1:0] a, b;
      logic v;
      a = W'($urandom);
      case ($urandom % 4)
        0: b = a;
        1: b = a ^ (W'(1) << ($urandom % W));
        default: b = W'($urandom);
      endcase
      v = ($urandom % 4) != 0;
      step(a, b, v, (a == b) ? "R2 random" : "R1 random");
    end

    for (int i = 0; i < LAT + 2; i++) step('0, '0, 1'b0, "R6 drain");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule